// File: doc/BRIEF.md
# I2C Interrupt Status and Vector Unit

This block sits beside the bit engine of an I2C controller and turns its single-cycle event pulses into latched status flags. A 16-bit mask register picks which flags may raise the interrupt. A vector register reports a 3-bit code for the most urgent flag that is both pending and enabled. Seven events are tracked: arbitration lost, no-acknowledge, register-access ready, receive data ready, transmit data ready, stop condition seen, and addressed as slave. The status register also mirrors two live bus levels: bus busy and receive shift register full.

An interrupt handler reads the vector register in a loop until it returns 0, handling one event per read. For most events, the read that reports a code also clears that flag. The receive-ready and transmit-ready flags stay set through vector reads. They clear only when the data path signals that the data register was read or written. Software can also clear selected flags by writing ones to the status register.

Top module: `i2c_irq_vector`

## Requirements
- R1: After a synchronous active-low reset, the mask register, all seven flags, the vector register and `irq_o` are all zero.
- R2: An event pulse sets its flag on the next clock edge, whether or not it is enabled. The status register at byte offset 0x08 shows the flags at these bits: arbitration lost 0, no-acknowledge 1, access ready 2, receive ready 3, transmit ready 4, stop seen 5, addressed as slave 6.
- R3: The mask register at byte offset 0x04 is written and read on bits 6..0. Bit k enables the event whose vector code is k+1. Bits 15..7 read 0.
- R4: The vector register at byte offset 0x28 reads the smallest code among flags that are set and enabled, or 0 if there is none. The codes are: arbitration lost 1, no-acknowledge 2, access ready 3, receive ready 4, transmit ready 5, stop seen 6, addressed as slave 7.
- R5: A read of the vector register that returns code 1, 2, 3, 6 or 7 clears that flag on the same clock edge. The next read then reports the next pending code.
- R6: A vector read returning 4 or 5 leaves the flag set. Flag 4 clears on a `rx_data_rd` strobe and flag 5 clears on a `tx_data_wr` strobe.
- R7: Writing the status register clears each of bits 0, 1, 2, 5 and 6 where the written value has a 1. A 0 leaves the bit unchanged. Bits 3 and 4 are not affected by status writes.
- R8: Status bit 11 mirrors `rx_shift_full` and bit 12 mirrors `bus_busy`. Both are read-only and no write changes them.
- R9: `irq_o` is high exactly when the vector register would read a nonzero code.
- R10: If an event pulse arrives in the same cycle as any clear of its flag, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 6 | Byte offset of the register access |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (carries read side effects) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_nack | input | 1 | No-acknowledge pulse |
| ev_acc_rdy | input | 1 | Register-access ready pulse |
| ev_rx_rdy | input | 1 | Receive data ready pulse |
| ev_tx_rdy | input | 1 | Transmit data ready pulse |
| ev_stop | input | 1 | Stop condition seen pulse |
| ev_slave | input | 1 | Addressed-as-slave pulse |
| bus_busy | input | 1 | Live bus-busy level |
| rx_shift_full | input | 1 | Live receive-shift-full level |
| rx_data_rd | input | 1 | Strobe: receive data register was read |
| tx_data_wr | input | 1 | Strobe: transmit data register was written |
| irq_o | output | 1 | Interrupt request |

## Verification
The properties assume that event inputs and strobes are single-cycle pulses that are clean at the clock edge. They also assume that `reg_rd` and `reg_wr` are never both high, and that `reg_addr` is stable while either strobe is high. The drain properties only claim a clear when no event for the same flag arrives in that cycle. The stimulus changes every input on the falling edge and holds it for one full cycle. It never raises both strobes together, and it creates a same-cycle collision only on purpose, to exercise R10.

// File: rtl/i2c_irq_pkg.sv
// Shared constants for the I2C interrupt status and vector unit.
// Assumes byte offsets fit in ADDR_W bits and that flag index k carries code k+1.
package i2c_irq_pkg;
    localparam int NUM_EVT  = 7;
    localparam int CODE_W   = 3;
    localparam int REG_W    = 16;
    localparam int ADDR_W   = 6;

    localparam logic [ADDR_W-1:0] OFS_MASK = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STAT = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_VEC  = 6'h28;

    // Flag indices (code minus one); status bits 0..6 follow the same order.
    localparam int IDX_RX   = 3;
    localparam int IDX_TX   = 4;
    localparam int BIT_RSF  = 11;
    localparam int BIT_BUSY = 12;

    // Status bits that are cleared by writing one.
    localparam logic [NUM_EVT-1:0] W1C_BITS = 7'b110_0111;

    typedef logic [NUM_EVT-1:0] evt_vec_t;
endpackage

// File: rtl/i2c_irq_flags.sv
// Bank of sticky event flags.
// Each bit sets on its pulse and clears on any clear request; a set beats a clear.
module i2c_irq_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    for (genvar gi = 0; gi < N; gi++) begin : g_flag
        logic q;
        // Hold one flag: reset, set priority, then clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          q <= 1'b0;
            else if (set_i[gi])  q <= 1'b1;
            else if (clr_i[gi])  q <= 1'b0;
        end
        assign flags_o[gi] = q;
    end
endmodule

// File: rtl/i2c_irq_prio.sv
// Priority encoder: the lowest set request index k yields code k+1, none yields 0.
// Assumes N < 2**W.
module i2c_irq_prio #(
    parameter int N = 7,
    parameter int W = 3
) (
    input  logic [N-1:0] req_i,
    output logic [W-1:0] code_o
);
    // Scan from the top down so the lowest index wins.
    always_comb begin
        code_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) code_o = W'(i + 1);
        end
    end
endmodule

// File: rtl/i2c_irq_regs.sv
// Register decode for mask, status and vector.
// Produces read data, the mask, and the per-flag clear requests from W1C, vector drain
// and data strobes. Assumes reg_rd and reg_wr are never both high.
module i2c_irq_regs
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  evt_vec_t          flags_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    input  logic              rx_data_rd,
    input  logic              tx_data_wr,
    output evt_vec_t          mask_o,
    output evt_vec_t          clr_o
);
    evt_vec_t mask_q;
    evt_vec_t w1c_clr;
    evt_vec_t drain_clr;
    evt_vec_t strobe_clr;
    logic     unused_wdata;

    assign unused_wdata = ^reg_wdata[REG_W-1:NUM_EVT];

    // Interrupt-enable register.
    always_ff @(posedge clk) begin
        if (!rst_n)                           mask_q <= '0;
        else if (reg_wr && reg_addr == OFS_MASK) mask_q <= reg_wdata[NUM_EVT-1:0];
    end
    assign mask_o = mask_q;

    // Write-one-to-clear from a status write.
    always_comb begin
        w1c_clr = '0;
        if (reg_wr && reg_addr == OFS_STAT) w1c_clr = reg_wdata[NUM_EVT-1:0] & W1C_BITS;
    end

    // Vector read drains the reported flag unless it is a data-ready flag.
    always_comb begin
        drain_clr = '0;
        if (reg_rd && reg_addr == OFS_VEC && code_i != '0 &&
            code_i != CODE_W'(IDX_RX + 1) && code_i != CODE_W'(IDX_TX + 1))
            drain_clr[code_i - CODE_W'(1)] = 1'b1;
    end

    // Data-register access strobes clear the data-ready flags.
    always_comb begin
        strobe_clr          = '0;
        strobe_clr[IDX_RX]  = rx_data_rd;
        strobe_clr[IDX_TX]  = tx_data_wr;
    end

    assign clr_o = w1c_clr | drain_clr | strobe_clr;

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_MASK: reg_rdata[NUM_EVT-1:0] = mask_q;
            OFS_STAT: begin
                reg_rdata[NUM_EVT-1:0] = flags_i;
                reg_rdata[BIT_RSF]     = rx_shift_full;
                reg_rdata[BIT_BUSY]    = bus_busy;
            end
            OFS_VEC:  reg_rdata[CODE_W-1:0] = code_i;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/i2c_irq_vector.sv
// Top of the I2C interrupt status and vector unit.
// Latches event pulses, masks them, encodes a priority vector and drives one request line.
// Assumes event inputs and strobes are synchronous single-cycle pulses.
module i2c_irq_vector
    import i2c_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              ev_arb_lost,
    input  logic              ev_nack,
    input  logic              ev_acc_rdy,
    input  logic              ev_rx_rdy,
    input  logic              ev_tx_rdy,
    input  logic              ev_stop,
    input  logic              ev_slave,
    input  logic              bus_busy,
    input  logic              rx_shift_full,
    input  logic              rx_data_rd,
    input  logic              tx_data_wr,
    output logic              irq_o
);
    evt_vec_t          ev_set;
    evt_vec_t          ev_clr;
    evt_vec_t          flags;
    evt_vec_t          mask;
    logic [CODE_W-1:0] vec_code;

    assign ev_set = {ev_slave, ev_stop, ev_tx_rdy, ev_rx_rdy, ev_acc_rdy, ev_nack, ev_arb_lost};

    i2c_irq_flags #(.N(NUM_EVT)) u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (ev_set),
        .clr_i  (ev_clr),
        .flags_o(flags)
    );

    i2c_irq_prio #(.N(NUM_EVT), .W(CODE_W)) u_prio (
        .req_i (flags & mask),
        .code_o(vec_code)
    );

    i2c_irq_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_addr     (reg_addr),
        .reg_wr       (reg_wr),
        .reg_rd       (reg_rd),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .flags_i      (flags),
        .code_i       (vec_code),
        .bus_busy     (bus_busy),
        .rx_shift_full(rx_shift_full),
        .rx_data_rd   (rx_data_rd),
        .tx_data_wr   (tx_data_wr),
        .mask_o       (mask),
        .clr_o        (ev_clr)
    );

    // Request line: any flag both set and enabled.
    assign irq_o = |(flags & mask);
endmodule

// File: rtl/i2c_irq_vector_chk.sv
// Property checker for i2c_irq_vector, attached by bind.
// Assumes the input rules stated in the brief.
module i2c_irq_vector_chk
    import i2c_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_rd,
    input logic [REG_W-1:0]  reg_rdata,
    input evt_vec_t          ev_set,
    input evt_vec_t          flags,
    input logic [CODE_W-1:0] vec_code,
    input logic              bus_busy,
    input logic              rx_data_rd,
    input logic              irq_o
);
    // R9: request line agrees with the encoder output.
    p_irq_matches_vec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == (vec_code != '0));

    // R2 / R10: a pulse always leaves its flag set.
    for (genvar gi = 0; gi < NUM_EVT; gi++) begin : g_set
        p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
            ev_set[gi] |=> flags[gi]);
    end

    // R5: a code-1 vector read with no new arbitration event drains flag 0.
    p_drain_code1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_VEC && vec_code == 3'd1 && !ev_set[0]) |=> !flags[0]);

    // R6: a code-4 vector read without the data strobe keeps flag 3.
    p_rx_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OFS_VEC && vec_code == 3'd4 && !rx_data_rd) |=> flags[IDX_RX]);

    // R8: status bit 12 follows the live bus-busy level.
    p_busy_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == OFS_STAT) |-> (reg_rdata[BIT_BUSY] == bus_busy));
endmodule

bind i2c_irq_vector i2c_irq_vector_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .ev_set    (ev_set),
    .flags     (flags),
    .vec_code  (vec_code),
    .bus_busy  (bus_busy),
    .rx_data_rd(rx_data_rd),
    .irq_o     (irq_o)
);

// File: tb/tb_i2c_irq_vector.sv
// Self-checking bench: table of event/mask/expected-vector rows, then directed tests.
module tb_i2c_irq_vector;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [6:0]  ev = '0;
    logic        bus_busy = 1'b0, rx_shift_full = 1'b0;
    logic        rx_data_rd = 1'b0, tx_data_wr = 1'b0;
    logic        irq_o;
    int          n_run = 0, n_fail = 0;

    localparam logic [5:0] A_MASK = 6'h04, A_STAT = 6'h08, A_VEC = 6'h28;

    always #10 clk = ~clk;

    i2c_irq_vector dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ev_arb_lost(ev[0]), .ev_nack(ev[1]), .ev_acc_rdy(ev[2]), .ev_rx_rdy(ev[3]),
        .ev_tx_rdy(ev[4]), .ev_stop(ev[5]), .ev_slave(ev[6]),
        .bus_busy(bus_busy), .rx_shift_full(rx_shift_full),
        .rx_data_rd(rx_data_rd), .tx_data_wr(tx_data_wr), .irq_o(irq_o)
    );

    // Row: {events[6:0], mask[6:0], expected vector[2:0]}
    localparam int NROW = 8;
    localparam logic [16:0] ROWS [NROW] = '{
        {7'h7F, 7'h7F, 3'd1}, {7'h7E, 7'h7F, 3'd2}, {7'h7F, 7'h7E, 3'd2},
        {7'h40, 7'h7F, 3'd7}, {7'h30, 7'h30, 3'd5}, {7'h18, 7'h10, 3'd5},
        {7'h0F, 7'h00, 3'd0}, {7'h24, 7'h20, 3'd6}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    // Look at read data without the read side effect.
    task automatic peek(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    // Read with side effect: data sampled before the edge that applies it.
    task automatic rd(input logic [5:0] a, output logic [15:0] d);
        @(negedge clk); reg_addr = a; reg_rd = 1'b1; #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic pulse(input logic [6:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    task automatic clear_all();
        wr(A_STAT, 16'hFFFF);
        @(negedge clk); rx_data_rd = 1'b1; tx_data_wr = 1'b1;
        @(negedge clk); rx_data_rd = 1'b0; tx_data_wr = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        peek(A_MASK, d); check("R1 mask", d, 16'h0);
        peek(A_STAT, d); check("R1 status", d, 16'h0);
        peek(A_VEC, d);  check("R1 vector", d, 16'h0);
        check("R1 irq", {15'b0, irq_o}, 16'h0);

        // R4 / R9: table walk
        for (int i = 0; i < NROW; i++) begin
            wr(A_MASK, {9'b0, ROWS[i][9:3]});
            pulse(ROWS[i][16:10]);
            peek(A_VEC, d); check("R4 table vector", d, {13'b0, ROWS[i][2:0]});
            check("R9 table irq", {15'b0, irq_o}, {15'b0, ROWS[i][2:0] != 3'd0});
            clear_all();
        end

        // R3: mask readback, upper bits zero
        wr(A_MASK, 16'hFFD5); peek(A_MASK, d); check("R3 mask readback", d, 16'h0055);

        // R2: masked event still latches in status, no irq
        wr(A_MASK, 16'h0000);
        pulse(7'h01);
        peek(A_STAT, d); check("R2 status latch", d, 16'h0001);
        check("R9 masked irq", {15'b0, irq_o}, 16'h0);
        clear_all();

        // R5: drain order 1,2,6,7 then 0
        wr(A_MASK, 16'h007F);
        pulse(7'h63);
        rd(A_VEC, d); check("R5 drain 1", d, 16'd1);
        rd(A_VEC, d); check("R5 drain 2", d, 16'd2);
        rd(A_VEC, d); check("R5 drain 6", d, 16'd6);
        rd(A_VEC, d); check("R5 drain 7", d, 16'd7);
        rd(A_VEC, d); check("R5 drain empty", d, 16'd0);
        check("R9 irq after drain", {15'b0, irq_o}, 16'h0);

        // R6: receive ready survives vector reads, clears on strobe
        pulse(7'h08);
        rd(A_VEC, d); check("R6 rx first", d, 16'd4);
        rd(A_VEC, d); check("R6 rx kept", d, 16'd4);
        @(negedge clk); rx_data_rd = 1'b1; @(negedge clk); rx_data_rd = 1'b0;
        peek(A_VEC, d); check("R6 rx cleared", d, 16'd0);
        pulse(7'h10);
        rd(A_VEC, d); check("R6 tx first", d, 16'd5);
        @(negedge clk); tx_data_wr = 1'b1; @(negedge clk); tx_data_wr = 1'b0;
        peek(A_VEC, d); check("R6 tx cleared", d, 16'd0);

        // R7: write-one-to-clear
        pulse(7'h3C);
        wr(A_STAT, 16'h0000);
        peek(A_STAT, d); check("R7 zero write", d, 16'h003C);
        wr(A_STAT, 16'h001C);
        peek(A_STAT, d); check("R7 clear bit2 only", d, 16'h0038);
        clear_all();

        // R8: live read-only bits
        @(negedge clk); bus_busy = 1'b1; rx_shift_full = 1'b1;
        wr(A_STAT, 16'hFFFF);
        peek(A_STAT, d); check("R8 busy/rsf", d, 16'h1800);
        @(negedge clk); bus_busy = 1'b0;
        peek(A_STAT, d); check("R8 busy follows", d, 16'h0800);
        rx_shift_full = 1'b0;

        // R10: event collides with its own drain
        pulse(7'h01);
        @(negedge clk); reg_addr = A_VEC; reg_rd = 1'b1; ev = 7'h01;
        @(negedge clk); reg_rd = 1'b0; ev = '0;
        peek(A_VEC, d); check("R10 set beats drain", d, 16'd1);
        clear_all();

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule